// File: doc/BRIEF.md
# Flash Write-Status Bit Generator

This block forms the byte that a host sees when it reads the nonvolatile bank. While the bank is idle, the byte is the array read data passed straight through. Once a program or erase has been launched, the bank runs that operation internally for a fixed number of clock cycles. During that time two bits of every read byte report completion status instead of stored data. The host polls these bits to learn when the write is done.

The top bit is the polling bit. During a byte program it is the inverse of the top bit of the byte being written. During an erase it is held at zero. When the operation ends, the stored value appears in its place: the true data after a program, or a one after an erase, since an erased byte reads FFh. The bit below it is the toggle bit. Each read strobe taken during the operation flips it, and it stops moving once the bank is idle.

An internal down-counter holds the busy state. It is loaded from one of three duration parameters, one each for program, sector erase and bank erase. The array and the command decoder sit outside this block. The launch strobe stands for the final write of an accepted command sequence.

Top module: `flash_wstat`

## Requirements
- R1: After reset the block is idle (`busy_o` low) and `rd_byte_o` equals `array_i`.
- R2: A `start_i` pulse sampled while idle with a valid `op_i` raises `busy_o` from the next cycle. `busy_o` stays high for exactly DURATION+1 cycles. DURATION is PROG_CYC for `op_i`=2'b00 (byte program), SECT_CYC for 2'b01 (sector erase) and BANK_CYC for 2'b10 (bank erase).
- R3: While busy with a program, bit 7 of `rd_byte_o` is the inverse of bit 7 of the `wbyte_i` value captured at launch.
- R4: While busy with either erase, bit 7 of `rd_byte_o` is 0.
- R5: While busy, bit 6 of `rd_byte_o` reads 0 on the first read strobe and flips once per read strobe. Clock cycles without a strobe leave it unchanged.
- R6: While busy, bits 5 to 0 of `rd_byte_o` follow bits 5 to 0 of `array_i`.
- R7: While idle, all of `rd_byte_o` equals `array_i`. Two consecutive idle reads therefore agree on bit 6, and an erased location (`array_i` = FFh) reads FFh after an erase completes.
- R8: A `start_i` pulse while busy is ignored. It changes neither the remaining duration nor the captured operation or byte.
- R9: `op_i`=2'b11 is reserved. A `start_i` pulse carrying it does not launch an operation.
- R10: Each new operation starts its toggle sequence at 0, whatever the toggle state was when the previous operation ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch strobe for the internal operation (one cycle) |
| op_i | input | 2 | Operation: 00 program, 01 sector erase, 10 bank erase, 11 reserved |
| wbyte_i | input | DATA_W | Byte being programmed, captured at launch |
| array_i | input | DATA_W | Array read data for the addressed location |
| rd_stb_i | input | 1 | Read strobe; one pulse per completed read |
| rd_byte_o | output | DATA_W | Byte returned to the host |
| busy_o | output | 1 | High while an internal operation runs |

## Verification
Two events can fall in the same cycle: a launch request and an operation already in progress. The bench provokes this by pulsing `start_i` with a bank-erase code and a different byte in the middle of a program. It then checks that the busy length still matches the program duration and that the polling bit still reflects the first byte. Read strobes can also be separated by odd numbers of idle clocks within one operation. That shows the toggle bit follows strobes and not clock edges.

// File: rtl/flash_wstat_pkg.sv
package flash_wstat_pkg;

  typedef enum logic [1:0] {
    OP_PROG = 2'b00,
    OP_SECT = 2'b01,
    OP_BANK = 2'b10,
    OP_RSVD = 2'b11
  } wop_e;

  function automatic logic op_ok(input logic [1:0] op);
    return op != OP_RSVD;
  endfunction

  function automatic logic op_is_erase(input logic [1:0] op);
    return (op == OP_SECT) || (op == OP_BANK);
  endfunction

  // Cycle count selected for an operation code
  function automatic int unsigned dur_of(input logic [1:0] op,
                                         input int unsigned p_cyc,
                                         input int unsigned s_cyc,
                                         input int unsigned b_cyc);
    case (op)
      OP_PROG: return p_cyc;
      OP_SECT: return s_cyc;
      default: return b_cyc;
    endcase
  endfunction

  // Polling bit value while the bank is busy
  function automatic logic poll_bit(input logic [1:0] op, input logic data_msb);
    return op_is_erase(op) ? 1'b0 : ~data_msb;
  endfunction

endpackage

// File: rtl/flash_busy_timer.sv
module flash_busy_timer
  import flash_wstat_pkg::*;
#(
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned PROG_CYC = 20,
  parameter int unsigned SECT_CYC = 60,
  parameter int unsigned BANK_CYC = 150
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [1:0]       op,
  output logic             busy,
  output logic [CNT_W-1:0] cnt
);

  logic [CNT_W-1:0] load_val;

  always_comb load_val = CNT_W'(dur_of(op, PROG_CYC, SECT_CYC, BANK_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (launch) begin
        busy <= 1'b1;
        cnt  <= load_val;
      end
    end else if (cnt == '0) begin
      busy <= 1'b0;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/flash_toggle_gen.sv
module flash_toggle_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic rd_stb,
  output logic tog
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tog <= 1'b0;
    else if (!busy)  tog <= 1'b0;
    else if (rd_stb) tog <= ~tog;
  end

endmodule

// File: rtl/flash_status_mux.sv
module flash_status_mux
  import flash_wstat_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              busy,
  input  logic [1:0]        op_q,
  input  logic [DATA_W-1:0] byte_q,
  input  logic              tog,
  input  logic [DATA_W-1:0] array_d,
  output logic [DATA_W-1:0] rd_byte
);

  localparam int unsigned POLL_IDX = DATA_W - 1;
  localparam int unsigned TOG_IDX  = DATA_W - 2;

  always_comb begin
    rd_byte = array_d;
    if (busy) begin
      rd_byte[POLL_IDX] = poll_bit(op_q, byte_q[POLL_IDX]);
      rd_byte[TOG_IDX]  = tog;
    end
  end

endmodule

// File: rtl/flash_wstat.sv
module flash_wstat
  import flash_wstat_pkg::*;
#(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned PROG_CYC = 20,
  parameter int unsigned SECT_CYC = 60,
  parameter int unsigned BANK_CYC = 150
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] wbyte_i,
  input  logic [DATA_W-1:0] array_i,
  input  logic              rd_stb_i,
  output logic [DATA_W-1:0] rd_byte_o,
  output logic              busy_o
);

  localparam int unsigned MAX_A = (PROG_CYC > SECT_CYC) ? PROG_CYC : SECT_CYC;
  localparam int unsigned MAX_D = (MAX_A > BANK_CYC) ? MAX_A : BANK_CYC;
  localparam int unsigned CNT_W = $clog2(MAX_D + 1);

  // Named internal events, also observed by the checker
  logic              busy;
  logic              launch_evt;
  logic [CNT_W-1:0]  cnt;
  logic              tog;
  logic [1:0]        op_q;
  logic [DATA_W-1:0] byte_q;

  assign launch_evt = start_i && !busy && op_ok(op_i);

  flash_busy_timer #(
    .CNT_W(CNT_W), .PROG_CYC(PROG_CYC), .SECT_CYC(SECT_CYC), .BANK_CYC(BANK_CYC)
  ) u_timer (
    .clk(clk), .rst_n(rst_n), .launch(launch_evt), .op(op_i),
    .busy(busy), .cnt(cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_PROG;
      byte_q <= '0;
    end else if (launch_evt) begin
      op_q   <= op_i;
      byte_q <= wbyte_i;
    end
  end

  flash_toggle_gen u_tog (
    .clk(clk), .rst_n(rst_n), .busy(busy), .rd_stb(rd_stb_i), .tog(tog)
  );

  flash_status_mux #(.DATA_W(DATA_W)) u_mux (
    .busy(busy), .op_q(op_q), .byte_q(byte_q), .tog(tog),
    .array_d(array_i), .rd_byte(rd_byte_o)
  );

  assign busy_o = busy;

endmodule

// File: rtl/flash_wstat_chk.sv
module flash_wstat_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [1:0]        op_i,
  input logic              rd_stb_i,
  input logic [DATA_W-1:0] array_i,
  input logic [DATA_W-1:0] rd_byte_o,
  input logic              busy,
  input logic [CNT_W-1:0]  cnt,
  input logic              tog,
  input logic [1:0]        op_q,
  input logic [DATA_W-1:0] byte_q
);

  AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_i && op_i != 2'b11) |=> busy); // R2

  AST_RSVD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_i && op_i == 2'b11) |=> !busy); // R9

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != '0) |=> (busy && cnt == CNT_W'($past(cnt) - 1'b1))); // R8

  AST_HOLD_OP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(op_q) && $stable(byte_q))); // R8

  AST_PROG_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q == 2'b00) |-> (rd_byte_o[DATA_W-1] != byte_q[DATA_W-1])); // R3

  AST_ERASE_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && op_q != 2'b00) |-> !rd_byte_o[DATA_W-1]); // R4

  AST_TOG_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rd_stb_i) |=> (tog != $past(tog))); // R5

  AST_TOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_stb_i) |=> (tog == $past(tog))); // R5

  AST_TOG_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !tog); // R10

  AST_LOW_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (rd_byte_o[DATA_W-3:0] == array_i[DATA_W-3:0])); // R6

  AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (rd_byte_o == array_i)); // R7

endmodule

bind flash_wstat flash_wstat_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .rd_stb_i(rd_stb_i),
  .array_i(array_i), .rd_byte_o(rd_byte_o), .busy(busy), .cnt(cnt), .tog(tog),
  .op_q(op_q), .byte_q(byte_q)
);

// File: tb/tb_flash_wstat.sv
module tb_flash_wstat;

  localparam int CLK_P = 10;
  localparam int P_CYC = 20;
  localparam int S_CYC = 60;
  localparam int B_CYC = 150;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] op = 2'b00;
  logic [7:0] wbyte = 8'h00;
  logic [7:0] arr = 8'h00;
  logic       rd = 1'b0;
  logic [7:0] rbyte;
  logic       busy;

  int checks = 0;
  int fails  = 0;
  int busy_n = 0;

  always #(CLK_P/2) clk = ~clk;

  flash_wstat #(.DATA_W(8), .PROG_CYC(P_CYC), .SECT_CYC(S_CYC), .BANK_CYC(B_CYC)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .op_i(op), .wbyte_i(wbyte),
    .array_i(arr), .rd_stb_i(rd), .rd_byte_o(rbyte), .busy_o(busy)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (busy) busy_n++;
  endtask

  task automatic launch(input logic [1:0] o, input logic [7:0] b);
    op = o; wbyte = b; start = 1'b1; busy_n = 0;
    tick();
    start = 1'b0;
  endtask

  task automatic do_read(output logic [7:0] v);
    rd = 1'b1;
    #1 v = rbyte;
    tick();
    rd = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) tick();
    tick();
  endtask

  task automatic t_reset();
    arr = 8'h5A;
    #1;
    check("R1 busy", busy, 0);
    check("R1 data", rbyte, 8'h5A);
  endtask

  task automatic t_durations();
    launch(2'b00, 8'h12);
    while (busy) tick();
    check("R2 program length", busy_n, P_CYC + 1);
    tick();
    launch(2'b01, 8'h00);
    while (busy) tick();
    check("R2 sector length", busy_n, S_CYC + 1);
    tick();
    launch(2'b10, 8'h00);
    while (busy) tick();
    check("R2 bank length", busy_n, B_CYC + 1);
    tick();
  endtask

  task automatic t_program();
    logic [7:0] v;
    arr = 8'h35;
    launch(2'b00, 8'h5C);
    check("R2 busy after launch", busy, 1);
    do_read(v);
    check("R3 poll bit", v[7], 1);
    check("R5 first toggle", v[6], 0);
    check("R6 low bits", v[5:0], 6'h35);
    repeat (3) tick();
    arr = 8'h2A;
    do_read(v);
    check("R5 second toggle", v[6], 1);
    check("R6 low bits changed", v[5:0], 6'h2A);
    repeat (2) tick();
    do_read(v);
    check("R5 third toggle", v[6], 0);
    launch(2'b00, 8'hA5);
    wait_idle();
    arr = 8'hA5;
    #1 check("R7 true data after program", rbyte, 8'hA5);
  endtask

  task automatic t_erase();
    logic [7:0] v;
    arr = 8'hC3;
    launch(2'b01, 8'h00);
    do_read(v);
    check("R4 sector poll bit", v[7], 0);
    check("R6 low bits erase", v[5:0], 6'h03);
    wait_idle();
    arr = 8'hFF;
    #1 check("R7 erased reads FF", rbyte, 8'hFF);
    arr = 8'hFF;
    launch(2'b10, 8'hFF);
    do_read(v);
    check("R4 bank poll bit", v[7], 0);
    wait_idle();
  endtask

  task automatic t_idle_reads();
    logic [7:0] a;
    logic [7:0] b;
    arr = 8'h4E;
    do_read(a);
    do_read(b);
    check("R7 idle bit6 stable", b[6], a[6]);
    check("R7 idle passthrough", b, 8'h4E);
  endtask

  task automatic t_start_while_busy();
    logic [7:0] v;
    arr = 8'h11;
    launch(2'b00, 8'h00);
    repeat (3) tick();
    op = 2'b10; wbyte = 8'hFF; start = 1'b1;
    tick();
    start = 1'b0;
    do_read(v);
    check("R8 poll bit keeps first byte", v[7], 1);
    while (busy) tick();
    check("R8 length not extended", busy_n, P_CYC + 1);
    tick();
  endtask

  task automatic t_reserved();
    arr = 8'h77;
    op = 2'b11; start = 1'b1;
    tick();
    start = 1'b0;
    check("R9 no launch", busy, 0);
    repeat (3) tick();
    check("R9 still idle", busy, 0);
    check("R9 data passthrough", rbyte, 8'h77);
  endtask

  task automatic t_restart();
    logic [7:0] v;
    arr = 8'h00;
    launch(2'b00, 8'h80);
    do_read(v);
    check("R10 first op toggle", v[6], 0);
    wait_idle();
    launch(2'b01, 8'h00);
    do_read(v);
    check("R10 new op toggle restarts", v[6], 0);
    do_read(v);
    check("R10 toggle advances", v[6], 1);
    wait_idle();
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_durations();
    t_program();
    t_erase();
    t_idle_reads();
    t_start_while_busy();
    t_reserved();
    t_restart();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule